// File: doc/BRIEF.md
# Write-only I2C configuration register slave

This block is a bus slave for the I2C two-wire protocol that accepts register writes only. It oversamples SCL and SDA with a fast system clock, finds START and STOP conditions, and compares the first byte of each transfer against a 7-bit device address. The top six address bits are fixed by a parameter, and the last bit follows an address-select input. After a matching write address, the next byte is taken as a sub-address. Every byte after that is a data byte that lands in one byte lane of a 120-bit configuration word, and the sub-address advances by one per byte.

Lanes are numbered from the top of the word down. Lane 0 holds bits 119 to 112 and lane k holds bits 119-8k down to 112-8k. A sub-address above 0x0F raises a sticky error flag, and the word stays frozen until a later transfer names a legal sub-address. SDA is modelled as an input plus an open-drain enable; when `sda_oe_o` is high, the pad pulls the line low.

Top module: `cfg_i2c_slave`

## Requirements
- R1: With `addr_sel_i` low the slave answers only to address 1100000. It drives SDA low during the 9th SCL pulse after a matching address byte. Any other address gets no acknowledge, and the rest of that transfer is ignored.
- R2: With `addr_sel_i` high the slave answers to 1100001 and no longer answers to 1100000.
- R3: Each acknowledge holds SDA low through the high phase of the 9th pulse and is released after that pulse. `sda_oe_o` changes only while SCL is low.
- R4: A data byte written at sub-address k (0x00..0x0E) lands in `cfg_o[119-8k -: 8]`. All other bits keep their values.
- R5: In a multi-byte write, successive data bytes go to successive sub-addresses, and every byte is acknowledged.
- R6: A sub-address byte above 0x0F sets `bad_sub_o`. The slave still acknowledges it and the data bytes that follow, but `cfg_o` does not change.
- R7: A later transfer whose sub-address is 0x00..0x0F clears `bad_sub_o`.
- R8: Sub-address 0x0F is legal: it leaves `bad_sub_o` low and a data byte there changes no bit of `cfg_o`.
- R9: A data byte whose auto-incremented sub-address has passed 0x0F sets `bad_sub_o` and is not written.
- R10: A matching address with the read/write bit at 1 is acknowledged. SDA is then released and the slave ignores further bytes until the next START.
- R11: A START or STOP seen in the middle of a byte abandons that byte. A repeated START begins a new address phase.
- R12: After reset `cfg_o` is all zero, `bad_sub_o` is low and SDA is released.
- R13: A single data byte changes at most one byte lane of `cfg_o`, and `cfg_o` only changes while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel_i | input | 1 | Address LSB select (low or floating gives 0) |
| sda_oe_o | output | 1 | Open-drain pull-down enable for SDA |
| cfg_o | output | 120 | Parallel configuration word |
| bad_sub_o | output | 1 | Sticky illegal sub-address flag |

## Verification
The bench uses the default parameters: 15 lanes, last legal sub-address 0x0F, and device prefix 110000. With these values a single short burst reaches the boundary between the last mapped lane (0x0E), the accepted-but-unmapped 0x0F, and the first out-of-range pointer 0x10. The bench drives SCL with phases of ten system clocks, which leaves time for the synchroniser delay. It drives SDA as a wired-AND of the master and the slave's pull-down, so acknowledge timing is seen as a real master would see it.

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter int         NUM_LANES  = 15,
  parameter int         LAST_SUB   = 15,
  parameter logic [5:0] DEV_PREFIX = 6'b110000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  input  logic                   addr_sel_i,
  output logic                   sda_oe_o,
  output logic [8*NUM_LANES-1:0] cfg_o,
  output logic                   bad_sub_o
);
  localparam int W = 8 * NUM_LANES;

  typedef enum logic [1:0] {ST_IDLE, ST_BITS, ST_ACK} state_t;
  typedef enum logic [1:0] {K_ADDR, K_SUB, K_DATA} kind_t;

  logic [2:0] scl_sh, sda_sh;
  logic [1:0] sel_sh;
  logic       scl_s, scl_p, sda_s, sda_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      sel_sh <= '0;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
      sel_sh <= {sel_sh[0], addr_sel_i};
    end

  assign scl_s = scl_sh[1];
  assign scl_p = scl_sh[2];
  assign sda_s = sda_sh[1];
  assign sda_p = sda_sh[2];

  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start_c  = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c   = scl_s & scl_p & ~sda_p & sda_s;

  state_t     st;
  kind_t      kind;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [7:0] ptr;
  logic       rd;
  logic       oe;
  logic       bad;

  wire byte_end  = (st == ST_BITS) && scl_fall && (cnt == 4'd8) && !start_c && !stop_c;
  wire addr_hit  = (sh[7:1] == {DEV_PREFIX, sel_sh[1]});
  wire ptr_over  = (ptr > 8'(LAST_SUB));
  wire data_done = byte_end && (kind == K_DATA);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= ST_IDLE;
      kind <= K_ADDR;
      cnt  <= '0;
      sh   <= '0;
      ptr  <= '0;
      rd   <= 1'b0;
      oe   <= 1'b0;
      bad  <= 1'b0;
    end else if (start_c) begin
      st   <= ST_BITS;
      kind <= K_ADDR;
      cnt  <= '0;
      oe   <= 1'b0;
    end else if (stop_c) begin
      st   <= ST_IDLE;
      oe   <= 1'b0;
    end else begin
      case (st)
        ST_BITS: begin
          if (scl_rise && cnt != 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_end) begin
            case (kind)
              K_ADDR: begin
                if (addr_hit) begin
                  oe <= 1'b1;
                  rd <= sh[0];
                  st <= ST_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end
              K_SUB: begin
                oe  <= 1'b1;
                st  <= ST_ACK;
                ptr <= sh;
                bad <= (sh > 8'(LAST_SUB));
              end
              default: begin
                oe <= 1'b1;
                st <= ST_ACK;
                if (ptr_over) bad <= 1'b1;
                else          ptr <= ptr + 8'd1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            oe  <= 1'b0;
            cnt <= '0;
            if (kind == K_ADDR && rd) begin
              st <= ST_IDLE;
            end else begin
              st   <= ST_BITS;
              kind <= (kind == K_ADDR) ? K_SUB : K_DATA;
            end
          end
        end
        default: ;
      endcase
    end

  logic [7:0] lane_q [NUM_LANES];

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        lane_q[i] <= '0;
      else if (data_done && ptr == 8'(i))
        lane_q[i] <= sh;
    assign cfg_o[W-1-8*i -: 8] = lane_q[i];
  end

  assign sda_oe_o  = oe;
  assign bad_sub_o = bad;
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk #(
  parameter int NUM_LANES = 15
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scl_i,
  input logic                   sda_oe_o,
  input logic [8*NUM_LANES-1:0] cfg_o,
  input logic                   bad_sub_o
);
  localparam int W = 8 * NUM_LANES;

  logic [W-1:0]         prev_cfg;
  logic [NUM_LANES-1:0] lane_chg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_cfg <= '0;
    else        prev_cfg <= cfg_o;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_chg
    assign lane_chg[i] = (prev_cfg[W-1-8*i -: 8] != cfg_o[W-1-8*i -: 8]);
  end

  // R3
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

  // R13
  one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_chg));

  // R13
  cfg_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_chg) |-> !scl_i);

  // R6
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bad_sub_o) && bad_sub_o) |-> $stable(cfg_o));

  // R7
  flag_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_sub_o != $past(bad_sub_o)) |-> !scl_i);
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .cfg_o(cfg_o), .bad_sub_o(bad_sub_o)
);

// File: tb/cfg_i2c_slave_test.sv
module cfg_i2c_slave_test;
  localparam int Q = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         scl = 1'b1;
  logic         sda_m = 1'b1;
  logic         addr_sel = 1'b0;
  logic         oe;
  logic [119:0] cfg;
  logic         bad;
  wire          sda_bus = sda_m & ~oe;

  int tests = 0;
  int fails = 0;
  logic [119:0] model = '0;

  always #2.5 clk = ~clk;

  cfg_i2c_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .addr_sel_i(addr_sel), .sda_oe_o(oe), .cfg_o(cfg), .bad_sub_o(bad)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_lane(input int k, input logic [7:0] v);
    model[119-8*k -: 8] = v;
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; wt(Q);
    scl = 1'b1;   wt(Q);
    sda_m = 1'b0; wt(Q);
    scl = 1'b0;   wt(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; wt(Q);
    scl = 1'b1;   wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wt(Q);
      scl = 1'b1;   wt(2 * Q);
      scl = 1'b0;   wt(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wt(Q);
    scl = 1'b1;   wt(Q);
    ack = ~sda_bus;
    wt(Q);
    scl = 1'b0;   wt(Q);
  endtask

  task automatic t_reset;
    chk("R12 cfg", 128'(cfg), 128'(0));
    chk("R12 flag", 128'(bad), 128'(0));
    chk("R12 oe", 128'(oe), 128'(0));
  endtask

  task automatic t_single;
    logic a0, a1, a2;
    i2c_start;
    send_byte(8'hC0, a0);
    chk("R3 release after ack", 128'(oe), 128'(0));
    send_byte(8'h00, a1);
    send_byte(8'hA5, a2);
    i2c_stop;
    set_lane(0, 8'hA5);
    chk("R1 addr ack", 128'(a0), 128'(1));
    chk("R3 sub ack", 128'(a1), 128'(1));
    chk("R4 lane0", 128'(cfg), 128'(model));
    i2c_start;
    send_byte(8'hC0, a0);
    send_byte(8'h02, a1);
    send_byte(8'h3C, a2);
    i2c_stop;
    set_lane(2, 8'h3C);
    chk("R4 lane2", 128'(cfg), 128'(model));
  endtask

  task automatic t_multi;
    logic a0, a1, a2, a3, a4;
    i2c_start;
    send_byte(8'hC0, a0);
    send_byte(8'h05, a1);
    send_byte(8'h11, a2);
    send_byte(8'h22, a3);
    send_byte(8'h33, a4);
    i2c_stop;
    set_lane(5, 8'h11); set_lane(6, 8'h22); set_lane(7, 8'h33);
    chk("R5 data acks", 128'({a2, a3, a4}), 128'(3'b111));
    chk("R5 R13 lanes 5..7", 128'(cfg), 128'(model));
  endtask

  task automatic t_wrong_addr;
    logic a0, a1, a2;
    i2c_start;
    send_byte(8'hC2, a0);
    send_byte(8'h01, a1);
    send_byte(8'hFF, a2);
    i2c_stop;
    chk("R1 foreign addr nack", 128'({a0, a1, a2}), 128'(0));
    chk("R1 foreign addr no write", 128'(cfg), 128'(model));
  endtask

  task automatic t_pin_high;
    logic a0, a1, a2;
    addr_sel = 1'b1; wt(Q);
    i2c_start;
    send_byte(8'hC0, a0);
    i2c_stop;
    chk("R2 old addr nack", 128'(a0), 128'(0));
    i2c_start;
    send_byte(8'hC2, a0);
    send_byte(8'h01, a1);
    send_byte(8'h77, a2);
    i2c_stop;
    set_lane(1, 8'h77);
    chk("R2 new addr ack", 128'(a0), 128'(1));
    chk("R2 write", 128'(cfg), 128'(model));
    addr_sel = 1'b0; wt(Q);
  endtask

  task automatic t_illegal;
    logic a0, a1, a2;
    i2c_start;
    send_byte(8'hC0, a0);
    send_byte(8'h15, a1);
    send_byte(8'h99, a2);
    i2c_stop;
    chk("R6 acks", 128'({a0, a1, a2}), 128'(3'b111));
    chk("R6 flag", 128'(bad), 128'(1));
    chk("R6 frozen", 128'(cfg), 128'(model));
    i2c_start;
    send_byte(8'hC0, a0);
    send_byte(8'h03, a1);
    send_byte(8'h44, a2);
    i2c_stop;
    set_lane(3, 8'h44);
    chk("R7 flag cleared", 128'(bad), 128'(0));
    chk("R7 write after clear", 128'(cfg), 128'(model));
  endtask

  task automatic t_sub0f;
    logic a0, a1, a2;
    i2c_start;
    send_byte(8'hC0, a0);
    send_byte(8'h0F, a1);
    send_byte(8'hEE, a2);
    i2c_stop;
    chk("R8 flag low", 128'(bad), 128'(0));
    chk("R8 no change", 128'(cfg), 128'(model));
  endtask

  task automatic t_past_end;
    logic a0, a1, a2, a3, a4;
    i2c_start;
    send_byte(8'hC0, a0);
    send_byte(8'h0E, a1);
    send_byte(8'h12, a2);
    send_byte(8'h34, a3);
    chk("R9 flag low at 0F", 128'(bad), 128'(0));
    send_byte(8'h56, a4);
    i2c_stop;
    set_lane(14, 8'h12);
    chk("R9 flag past end", 128'(bad), 128'(1));
    chk("R9 only lane14", 128'(cfg), 128'(model));
    i2c_start;
    send_byte(8'hC0, a0);
    send_byte(8'h00, a1);
    i2c_stop;
    chk("R7 cleared by sub only", 128'(bad), 128'(0));
  endtask

  task automatic t_read;
    logic a0, a1, a2;
    i2c_start;
    send_byte(8'hC1, a0);
    send_byte(8'h08, a1);
    send_byte(8'hAB, a2);
    i2c_stop;
    chk("R10 read ack", 128'(a0), 128'(1));
    chk("R10 later nack", 128'({a1, a2}), 128'(0));
    chk("R10 no write", 128'(cfg), 128'(model));
  endtask

  task automatic t_restart;
    logic a0, a1, a2;
    i2c_start;
    send_byte(8'hC0, a0);
    send_byte(8'h04, a1);
    send_bits(8'hF0, 4);
    i2c_start;
    send_byte(8'hC0, a0);
    send_byte(8'h04, a1);
    send_byte(8'h5A, a2);
    i2c_stop;
    set_lane(4, 8'h5A);
    chk("R11 repeated start", 128'(cfg), 128'(model));
    i2c_start;
    send_byte(8'hC0, a0);
    send_byte(8'h09, a1);
    send_bits(8'h00, 3);
    i2c_stop;
    chk("R11 stop mid-byte", 128'(cfg), 128'(model));
    chk("R11 idle oe", 128'(oe), 128'(0));
  endtask

  initial begin
    wt(5);
    rst_n = 1'b1;
    wt(5);
    t_reset;
    t_single;
    t_multi;
    t_wrong_addr;
    t_pin_high;
    t_illegal;
    t_sub0f;
    t_past_end;
    t_read;
    t_restart;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule